// File: doc/BRIEF.md
# Sticky Event Register with Masked Summary

This block keeps an 8-bit register of latched events. Four event sources each set a fixed bit on a rising edge: operation complete, query error, execution error and command error. A power-up bit sets by itself once reset ends. A set bit stays set until the host reads the register through a query port. That read returns the contents and empties the register in the same access.

The host can also write and read back an enable register of the same width. A single summary output is high when at least one latched event is also enabled. This output drives the event summary bit of a higher-level status byte. Event detection itself is done outside the block.

Top module: `evt_stat_core`

## Requirements
- R1: Bit positions are fixed. Power-up is bit 7 (weight 128), command error is bit 5 (32), execution error is bit 4 (16), query error is bit 2 (4) and operation complete is bit 0 (1). The value read is the weighted sum of the set bits.
- R2: Bits 6, 3 and 1 of the event register always read as zero.
- R3: While `qry_rd_i` is high, `qry_rdata_o` shows the register contents. At the next clock edge the register is cleared.
- R4: When no query read is made, a set event bit stays set whatever its input does.
- R5: If an event edge arrives in the same cycle as a query read, that event's bit is set after the clear and the event is kept.
- R6: An event bit sets only on a low-to-high transition of its input. An input held high after a clear does not set the bit again.
- R7: The power-up bit sets at the first clock edge after reset is released, and at no later edge.
- R8: A write stores `en_wdata_i` into the enable register, which `en_rdata_o` returns from the next cycle. Data written to bits 6, 3 and 1 is discarded, so those bits read as zero.
- R9: `sum_o` is high exactly when some bit is set in both the event register and the enable register.
- R10: While reset is held, the event register, the enable register and `sum_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_op_done_i | input | 1 | Operation-complete event source |
| ev_qry_err_i | input | 1 | Query-error event source |
| ev_exec_err_i | input | 1 | Execution-error event source |
| ev_cmd_err_i | input | 1 | Command-error event source |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register read-back |
| qry_rd_i | input | 1 | Query read; clears the event register at the next edge |
| qry_rdata_o | output | 8 | Event register contents |
| sum_o | output | 1 | Masked OR of event and enable registers |

## Verification
Single one-cycle pulses on each source, one after another, separate the bit positions and show that earlier bits stay set. An input held high across a clear separates edge capture from level capture. A pulse that lands in the same cycle as a query read shows whether the clear or the set wins. Enable patterns are chosen to cover or to miss the latched bits, and that is how a masked summary is told apart from a plain OR of the events.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;
  localparam int REG_W   = 8;
  localparam int POS_PON = 7;
  localparam int POS_CME = 5;
  localparam int POS_EXE = 4;
  localparam int POS_QYE = 2;
  localparam int POS_OPC = 0;

  function automatic logic [REG_W-1:0] used_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[POS_PON] = 1'b1;
    m[POS_CME] = 1'b1;
    m[POS_EXE] = 1'b1;
    m[POS_QYE] = 1'b1;
    m[POS_OPC] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] USED_MASK = used_mask();

  // any enabled event present
  function automatic logic masked_any(input logic [REG_W-1:0] ev,
                                      input logic [REG_W-1:0] en);
    return |(ev & en);
  endfunction
endpackage

// File: rtl/evt_edge_cell.sv
module evt_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic clr_i,
  output logic set_o,
  output logic bit_o
);
  logic prev_q;
  logic bit_q;

  // rising edge of the source is the set event
  assign set_o = src_i & ~prev_q;
  assign bit_o = bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      prev_q <= src_i;
      // set wins over clear in the same cycle
      bit_q  <= clr_i ? set_o : (bit_q | set_o);
    end
  end
endmodule

// File: rtl/evt_por_cell.sv
module evt_por_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic set_o,
  output logic bit_o
);
  logic pend_q;
  logic bit_q;

  assign set_o = pend_q;
  assign bit_o = bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      bit_q  <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      bit_q  <= clr_i ? set_o : (bit_q | set_o);
    end
  end
endmodule

// File: rtl/evt_enable_reg.sv
module evt_enable_reg
  import evt_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (wr_i) q <= wdata_i & USED_MASK;
  end

  assign q_o = q;
endmodule

// File: rtl/evt_summary.sv
module evt_summary
  import evt_stat_pkg::*;
(
  input  logic [REG_W-1:0] ev_i,
  input  logic [REG_W-1:0] en_i,
  output logic             sum_o
);
  assign sum_o = masked_any(ev_i, en_i);
endmodule

// File: rtl/evt_stat_core.sv
module evt_stat_core
  import evt_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_op_done_i,
  input  logic             ev_qry_err_i,
  input  logic             ev_exec_err_i,
  input  logic             ev_cmd_err_i,
  input  logic             en_wr_i,
  input  logic [REG_W-1:0] en_wdata_i,
  output logic [REG_W-1:0] en_rdata_o,
  input  logic             qry_rd_i,
  output logic [REG_W-1:0] qry_rdata_o,
  output logic             sum_o
);
  // named internal events for the checker
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] ev_vec;
  logic [REG_W-1:0] en_vec;
  logic             clr_evt;

  assign clr_evt = qry_rd_i;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i == POS_PON) begin : g_por
      evt_por_cell u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(clr_evt),
        .set_o(set_vec[i]),
        .bit_o(ev_vec[i])
      );
    end else if (USED_MASK[i]) begin : g_edge
      logic src;
      assign src = (i == POS_CME) ? ev_cmd_err_i  :
                   (i == POS_EXE) ? ev_exec_err_i :
                   (i == POS_QYE) ? ev_qry_err_i  : ev_op_done_i;
      evt_edge_cell u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .src_i(src),
        .clr_i(clr_evt),
        .set_o(set_vec[i]),
        .bit_o(ev_vec[i])
      );
    end else begin : g_none
      assign set_vec[i] = 1'b0;
      assign ev_vec[i]  = 1'b0;
    end
  end

  evt_enable_reg u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (en_wr_i),
    .wdata_i(en_wdata_i),
    .q_o    (en_vec)
  );

  evt_summary u_sum (
    .ev_i (ev_vec),
    .en_i (en_vec),
    .sum_o(sum_o)
  );

  assign qry_rdata_o = ev_vec;
  assign en_rdata_o  = en_vec;
endmodule

// File: rtl/evt_stat_chk.sv
module evt_stat_chk
  import evt_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en_wr_i,
  input logic [REG_W-1:0] en_wdata_i,
  input logic [REG_W-1:0] en_rdata_o,
  input logic             qry_rd_i,
  input logic [REG_W-1:0] qry_rdata_o,
  input logic             sum_o,
  input logic [REG_W-1:0] set_vec
);
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_rdata_o & ~USED_MASK) == '0);

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_rd_i && set_vec == '0) |=> qry_rdata_o == '0);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_rd_i |=> (qry_rdata_o & $past(qry_rdata_o)) == $past(qry_rdata_o));

  p_keep_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    qry_rd_i |=> (qry_rdata_o & $past(set_vec)) == $past(set_vec));

  p_en_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> en_rdata_o == ($past(en_wdata_i) & USED_MASK));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_rdata_o));

  p_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sum_o == ($countones(qry_rdata_o & en_rdata_o) != 0));
endmodule

bind evt_stat_core evt_stat_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_wr_i    (en_wr_i),
  .en_wdata_i (en_wdata_i),
  .en_rdata_o (en_rdata_o),
  .qry_rd_i   (qry_rd_i),
  .qry_rdata_o(qry_rdata_o),
  .sum_o      (sum_o),
  .set_vec    (set_vec)
);

// File: tb/sim_evt_stat_core.sv
`timescale 1ns/1ps
module sim_evt_stat_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op = 1'b0, qe = 1'b0, ex = 1'b0, ce = 1'b0;
  logic       en_wr = 1'b0;
  logic [7:0] en_wd = 8'h00;
  logic [7:0] en_rd;
  logic       qry = 1'b0;
  logic [7:0] q_rd;
  logic       sum;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_stat_core u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_op_done_i(op), .ev_qry_err_i(qe), .ev_exec_err_i(ex), .ev_cmd_err_i(ce),
    .en_wr_i(en_wr), .en_wdata_i(en_wd), .en_rdata_o(en_rd),
    .qry_rd_i(qry), .qry_rdata_o(q_rd), .sum_o(sum)
  );

  // behavioural reference model, integer weights
  int m_ev, m_en;
  bit m_por;
  bit p_op, p_qe, p_ex, p_ce;

  always @(posedge clk) begin
    int add;
    if (!rst_n) begin
      m_ev = 0; m_en = 0; m_por = 1;
      p_op = 0; p_qe = 0; p_ex = 0; p_ce = 0;
    end else begin
      add = 0;
      if (m_por)       add += 128;
      if (ce && !p_ce) add += 32;
      if (ex && !p_ex) add += 16;
      if (qe && !p_qe) add += 4;
      if (op && !p_op) add += 1;
      if (qry) m_ev = add;
      else     m_ev = m_ev | add;
      if (en_wr) m_en = en_wd & (128 + 32 + 16 + 4 + 1);
      p_op = op; p_qe = qe; p_ex = ex; p_ce = ce;
      m_por = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 event reg vs model", int'(q_rd), m_ev);
      check("R8 enable reg vs model", int'(en_rd), m_en);
      check("R9 summary vs model", int'(sum), ((m_ev & m_en) != 0) ? 1 : 0);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #20000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    check("R10 event reg in reset", int'(q_rd), 0);
    check("R10 enable in reset", int'(en_rd), 0);
    check("R10 summary in reset", int'(sum), 0);
    rst_n = 1'b1;
    tick();
    check("R7 power-up bit after reset", int'(q_rd), 8'h80);
    tick();
    check("R7 power-up sets only once", int'(q_rd), 8'h80);
    qry = 1'b1;
    check("R3 read returns contents", int'(q_rd), 8'h80);
    tick(); qry = 1'b0;
    check("R3 cleared after read", int'(q_rd), 0);
    tick();
    check("R7 power-up not set again", int'(q_rd), 0);

    ce = 1'b1; tick(); ce = 1'b0;
    check("R1 command error bit 5", int'(q_rd), 32);
    ex = 1'b1; tick(); ex = 1'b0;
    check("R4 sticky plus R1 execution bit 4", int'(q_rd), 48);
    qe = 1'b1; tick(); qe = 1'b0;
    op = 1'b1; tick(); op = 1'b0;
    check("R1 weighted sum 32+16+4+1", int'(q_rd), 53);
    check("R2 unused bits zero", int'(q_rd & 8'h4A), 0);
    repeat (3) tick();
    check("R4 bits held without read", int'(q_rd), 53);

    qry = 1'b1; tick(); qry = 1'b0;
    check("R3 clear all", int'(q_rd), 0);

    qe = 1'b1; tick();
    check("R6 edge sets query error", int'(q_rd), 4);
    qry = 1'b1; tick(); qry = 1'b0;
    repeat (3) tick();
    check("R6 held level does not reset bit", int'(q_rd), 0);
    qe = 1'b0; tick();

    op = 1'b1; qry = 1'b1; tick(); op = 1'b0; qry = 1'b0;
    check("R5 event kept on collision", int'(q_rd), 1);

    en_wr = 1'b1; en_wd = 8'hFF; tick(); en_wr = 1'b0;
    check("R8 unused enable bits dropped", int'(en_rd), 8'hB5);
    en_wr = 1'b1; en_wd = 8'h4A; tick(); en_wr = 1'b0;
    check("R8 write to unused only", int'(en_rd), 0);
    check("R9 summary low when none enabled", int'(sum), 0);
    en_wr = 1'b1; en_wd = 8'h20; tick(); en_wr = 1'b0;
    check("R9 summary masked off", int'(sum), 0);
    ce = 1'b1; tick(); ce = 1'b0;
    check("R9 summary high on enabled event", int'(sum), 1);
    en_wr = 1'b1; en_wd = 8'h01; tick(); en_wr = 1'b0;
    check("R9 summary via other enabled bit", int'(sum), 1);
    qry = 1'b1; tick(); qry = 1'b0;
    check("R9 summary low after clear", int'(sum), 0);
    check("R8 enable survives event read", int'(en_rd), 1);
    tick();
    finish_run();
  end
endmodule